// File: doc/BRIEF.md
# Energy-to-Pulse Frequency Output Generator

This block sits after the power multiplier of an electricity meter. Each time its valid strobe is high it takes one signed active-power sample. It adds the sample's magnitude into an energy accumulator and turns the energy into pulse trains. A fast calibration output (`cal_out`) fires once per small energy quantum. Two slow outputs (`fout1`, `fout2`) fire in turn, once per large quantum. Because they alternate, they can step a two-phase electromechanical counter directly. A registered flag (`rev_flag`) shows the sign of the most recent sample.

The slow quantum is set by a two-bit rate select. The calibration select sets how many calibration pulses make up one slow pulse. Both pulse trains come from the same accumulator, so every slow pulse starts on the same edge as a calibration pulse. Pulse widths are clock-count parameters. When pulses arrive faster than a nominal width allows, a pulse is cut short, and a minimum low gap separates it from the next pulse. Samples whose magnitude lies below a no-load floor are discarded, so a meter with no load does not creep.

Top module: `energy_pulse_gen`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. Reset clears the accumulator, so energy stored before reset never produces a pulse afterwards.
- R2: On each clock with `pwr_valid` high, `rev_flag` takes the sign bit of `pwr_sample` (1 for negative) one clock later, including for samples below the no-load floor. Without `pwr_valid` it holds its value.
- R3: The calibration quantum is `(F_BASE << (3 - fsel)) >> s`, where `s` = `CAL_SH_LO` if `cal_sel` = 0 and `CAL_SH_HI` if `cal_sel` = 1. One calibration event is produced each time the accumulated magnitude reaches the quantum. The quantum is then subtracted, and the remainder carries over. At most one event occurs per clock.
- R4: Every 2^s calibration events produce one slow event. Each slow pulse therefore stands for `F_BASE << (3 - fsel)` units of energy, whatever `cal_sel` is. A slow pulse rises on the same edge as the calibration pulse of the same event.
- R5: Slow pulses alternate between `fout1` and `fout2`, and the first pulse after reset is on `fout1`. The two outputs are never high together.
- R6: A slow pulse is high for `F_W` clocks unless it is truncated (R8). Between any two slow pulses the outputs stay low for at least `F_GAP` clocks.
- R7: A calibration pulse is high for `CF_W` clocks. In the high-rate mode (`fsel` = 3 and `cal_sel` = 1) it is high for `CF_HF_W` clocks instead.
- R8: If a new event arrives while a pulse is high, the pulse ends at the next edge and the new event is held pending. The pending pulse starts after the minimum gap: `F_GAP` clocks on the slow pair, one clock on `cal_out`.
- R9: A sample whose magnitude is below `NOLOAD_TH` adds no energy. A sample whose magnitude equals `NOLOAD_TH` adds its full magnitude.
- R10: A negative sample adds its magnitude, exactly as a positive sample of the same size does.
- R11: When a sample is accepted on edge E and brings the accumulator to the quantum, and the shaper is idle, the output pulse is high from edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_valid | input | 1 | Sample strobe |
| pwr_sample | input | PWR_W | Signed active-power sample |
| fsel | input | 2 | Slow-rate select |
| cal_sel | input | 1 | Calibration-rate select |
| fout1 | output | 1 | Slow pulse, phase A |
| fout2 | output | 1 | Slow pulse, phase B |
| cal_out | output | 1 | Calibration pulse |
| rev_flag | output | 1 | Sign of the last sample |

## Verification
The main function is tried with every rate select and both calibration selects. It is fed positive and negative magnitudes, magnitudes just below and exactly at the no-load floor, and magnitudes that leave a remainder in the accumulator. Comparing pulse counts across these patterns separates a wrong quantum, a wrong ratio, a wrong sign treatment and an off-by-one floor. The split between `fout1` and `fout2` exposes broken alternation, and the measured high times tell the normal calibration width from the high-rate one. Directed tests cover the edge at which a pulse starts, back-to-back events that force truncation, and energy left over across a reset.

// File: rtl/epg_pkg.sv
package epg_pkg;

  // Energy per calibration event for a given rate and calibration select.
  function automatic logic [31:0] quantum_cf(input logic [1:0] fsel, input logic cal,
                                             input logic [31:0] base, input int sh_lo,
                                             input int sh_hi);
    logic [31:0] q_slow;
    q_slow = base << (2'd3 - fsel);
    return q_slow >> (cal ? sh_hi : sh_lo);
  endfunction

  // Last value of the calibration-to-slow event counter.
  function automatic logic [7:0] ratio_top(input logic cal, input int sh_lo, input int sh_hi);
    return 8'((1 << (cal ? sh_hi : sh_lo)) - 1);
  endfunction

  // High-rate calibration mode selects the short calibration width.
  function automatic logic hf_mode(input logic [1:0] fsel, input logic cal);
    return (fsel == 2'b11) && cal;
  endfunction

  typedef enum logic {SH_IDLE = 1'b0, SH_HIGH = 1'b1} shaper_state_t;

endpackage

// File: rtl/epg_energy_accum.sv
module epg_energy_accum
  import epg_pkg::*;
#(
  parameter int PWR_W     = 16,
  parameter int ACC_W     = 24,
  parameter int F_BASE    = 1024,
  parameter int CAL_SH_LO = 2,
  parameter int CAL_SH_HI = 4,
  parameter int NOLOAD_TH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_valid,
  input  logic signed [PWR_W-1:0] pwr_sample,
  input  logic [1:0]              fsel,
  input  logic                    cal_sel,
  output logic                    cf_evt,
  output logic                    f_evt,
  output logic                    rev_flag
);

  logic [PWR_W-1:0] mag;
  logic             above_floor;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] add_amt;
  logic [ACC_W-1:0] q_cf;
  logic [7:0]       rcnt;
  logic [7:0]       rtop;

  // Magnitude: the most negative code maps to its unsigned value.
  assign mag         = pwr_sample[PWR_W-1] ? PWR_W'(-pwr_sample) : PWR_W'(pwr_sample);
  assign above_floor = mag >= PWR_W'(NOLOAD_TH);
  assign add_amt     = (pwr_valid && above_floor) ? ACC_W'(mag) : '0;
  assign q_cf        = ACC_W'(quantum_cf(fsel, cal_sel, 32'(F_BASE), CAL_SH_LO, CAL_SH_HI));
  assign rtop        = ratio_top(cal_sel, CAL_SH_LO, CAL_SH_HI);

  // Named events seen by the shapers and the assertions.
  assign cf_evt = acc >= q_cf;
  assign f_evt  = cf_evt && (rcnt >= rtop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else begin
      acc <= acc + add_amt - (cf_evt ? q_cf : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
    end else if (cf_evt) begin
      rcnt <= f_evt ? 8'd0 : rcnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_flag <= 1'b0;
    end else if (pwr_valid) begin
      rev_flag <= pwr_sample[PWR_W-1];
    end
  end

  // R9: a sample under the floor leaves the accumulator untouched.
  a_r9_noload_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_valid && !above_floor && !cf_evt) |=> (acc == $past(acc)));

  // R3: with no sample and no event the stored energy holds.
  a_r3_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_valid && !cf_evt) |=> $stable(acc));

  // R2: sign flag follows the accepted sample.
  a_r2_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |=> (rev_flag == $past(pwr_sample[PWR_W-1])));

  // R2: sign flag holds without a sample.
  a_r2_sign_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_valid |=> $stable(rev_flag));

  // R4: every slow event coincides with a calibration event.
  a_r4_slow_on_cal: assert property (@(posedge clk) disable iff (!rst_n)
    f_evt |-> cf_evt);

endmodule

// File: rtl/epg_pulse_shaper.sv
module epg_pulse_shaper
  import epg_pkg::*;
#(
  parameter int NOUT = 2,
  parameter int GAP  = 4,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt,
  input  logic [CW-1:0]   width,
  output logic [NOUT-1:0] pulse
);

  localparam int IW = (NOUT > 1) ? $clog2(NOUT) : 1;
  localparam int GW = $clog2(GAP + 1);
  localparam int LW = GW + 1;

  shaper_state_t   st;
  logic            pend;
  logic [CW-1:0]   cnt;
  logic [GW-1:0]   gap;
  logic [IW-1:0]   phase;
  logic [NOUT-1:0] pulse_q;
  logic            start;
  logic            stop;

  assign start = (st == SH_IDLE) && (gap == '0) && (evt || pend);
  assign stop  = (st == SH_HIGH) && ((cnt >= width) || evt || pend);
  assign pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      pend    <= 1'b0;
      cnt     <= '0;
      gap     <= '0;
      phase   <= '0;
      pulse_q <= '0;
    end else if (start) begin
      st      <= SH_HIGH;
      cnt     <= CW'(1);
      pulse_q <= NOUT'(1) << phase;
      phase   <= (phase == IW'(NOUT - 1)) ? '0 : phase + IW'(1);
      pend    <= pend & evt;
    end else if (stop) begin
      st      <= SH_IDLE;
      pulse_q <= '0;
      gap     <= GW'(GAP - 1);
      pend    <= pend | evt;
    end else if (st == SH_HIGH) begin
      cnt <= cnt + CW'(1);
    end else begin
      if (gap != '0) gap <= gap - GW'(1);
      pend <= pend | evt;
    end
  end

  // Checker state: low run length and previous output value.
  logic            any_hi;
  logic            any_hi_d;
  logic [LW-1:0]   low_run;
  logic [NOUT-1:0] pulse_d;

  assign any_hi = |pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_hi_d <= 1'b0;
      low_run  <= LW'(GAP);
      pulse_d  <= '0;
    end else begin
      any_hi_d <= any_hi;
      pulse_d  <= pulse_q;
      if (any_hi) low_run <= '0;
      else if (low_run < LW'(GAP)) low_run <= low_run + LW'(1);
    end
  end

  // R5: at most one output high.
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));

  // R6, R7: the high time never exceeds the selected width.
  a_r6_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SH_HIGH) && $stable(width)) |-> (cnt <= width));

  // R8: every rise is preceded by the minimum low gap.
  a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hi && !any_hi_d) |-> (low_run >= LW'(GAP)));

  // R11: an event reaching an idle shaper starts a pulse on the next edge.
  a_r11_prompt_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SH_IDLE) && (gap == '0) && evt) |=> (pulse_q != '0));

  generate
    if (NOUT == 2) begin : g_alt
      logic last_b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_b <= 1'b1;
        else if (pulse_q[0] && !pulse_d[0]) last_b <= 1'b0;
        else if (pulse_q[1] && !pulse_d[1]) last_b <= 1'b1;
      end

      // R5: phase A only follows phase B, and the reverse.
      a_r5_alt_a: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q[0] && !pulse_d[0]) |-> last_b);
      a_r5_alt_b: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q[1] && !pulse_d[1]) |-> !last_b);
    end
  endgenerate

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
  import epg_pkg::*;
#(
  parameter int PWR_W     = 16,
  parameter int ACC_W     = 24,
  parameter int F_BASE    = 1024,
  parameter int CAL_SH_LO = 2,
  parameter int CAL_SH_HI = 4,
  parameter int NOLOAD_TH = 16,
  parameter int F_W       = 1000000,
  parameter int F_GAP     = 4,
  parameter int CF_W      = 900000,
  parameter int CF_HF_W   = 180
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_valid,
  input  logic signed [PWR_W-1:0] pwr_sample,
  input  logic [1:0]              fsel,
  input  logic                    cal_sel,
  output logic                    fout1,
  output logic                    fout2,
  output logic                    cal_out,
  output logic                    rev_flag
);

  localparam int CF_MAXW = (CF_W > CF_HF_W) ? CF_W : CF_HF_W;
  localparam int FCW     = $clog2(F_W + 1);
  localparam int CCW     = $clog2(CF_MAXW + 1);

  logic          cf_evt;
  logic          f_evt;
  logic [1:0]    fpair;
  logic [0:0]    cpulse;
  logic [CCW-1:0] cf_width;

  assign cf_width = hf_mode(fsel, cal_sel) ? CCW'(CF_HF_W) : CCW'(CF_W);

  epg_energy_accum #(
    .PWR_W(PWR_W), .ACC_W(ACC_W), .F_BASE(F_BASE),
    .CAL_SH_LO(CAL_SH_LO), .CAL_SH_HI(CAL_SH_HI), .NOLOAD_TH(NOLOAD_TH)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_sample(pwr_sample),
    .fsel(fsel), .cal_sel(cal_sel), .cf_evt(cf_evt), .f_evt(f_evt), .rev_flag(rev_flag)
  );

  epg_pulse_shaper #(.NOUT(2), .GAP(F_GAP), .CW(FCW)) u_slow (
    .clk(clk), .rst_n(rst_n), .evt(f_evt), .width(FCW'(F_W)), .pulse(fpair)
  );

  epg_pulse_shaper #(.NOUT(1), .GAP(1), .CW(CCW)) u_cal (
    .clk(clk), .rst_n(rst_n), .evt(cf_evt), .width(cf_width), .pulse(cpulse)
  );

  assign fout1   = fpair[0];
  assign fout2   = fpair[1];
  assign cal_out = cpulse[0];

endmodule

// File: tb/sim_energy_pulse_gen.sv
`timescale 1ns/1ps
module sim_energy_pulse_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_valid = 1'b0;
  logic signed [15:0] pwr_sample = '0;
  logic [1:0] fsel = 2'd0;
  logic cal_sel = 1'b0;
  logic fout1, fout2, cal_out, rev_flag;

  always #5 clk = ~clk;

  energy_pulse_gen #(
    .PWR_W(16), .ACC_W(24), .F_BASE(1024), .CAL_SH_LO(2), .CAL_SH_HI(4),
    .NOLOAD_TH(16), .F_W(8), .F_GAP(4), .CF_W(6), .CF_HF_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_sample(pwr_sample),
    .fsel(fsel), .cal_sel(cal_sel), .fout1(fout1), .fout2(fout2),
    .cal_out(cal_out), .rev_flag(rev_flag)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge.
  int cf_rise, f1_rise, f2_rise, both_hi, unsync;
  int cf_run, f_run, cf_last, f_last;
  logic cf_p, f1_p, f2_p;

  task automatic mon_clear();
    cf_rise = 0; f1_rise = 0; f2_rise = 0; both_hi = 0; unsync = 0;
    cf_run = 0; f_run = 0; cf_last = 0; f_last = 0;
  endtask

  initial begin
    mon_clear();
    cf_p = 0; f1_p = 0; f2_p = 0;
  end

  always @(negedge clk) begin
    if (cal_out && !cf_p) cf_rise++;
    if (fout1 && !f1_p) f1_rise++;
    if (fout2 && !f2_p) f2_rise++;
    if (((fout1 && !f1_p) || (fout2 && !f2_p)) && !(cal_out && !cf_p)) unsync++;
    if (fout1 && fout2) both_hi++;
    if (cal_out) cf_run++;
    else if (cf_run > 0) begin cf_last = cf_run; cf_run = 0; end
    if (fout1 || fout2) f_run++;
    else if (f_run > 0) begin f_last = f_run; f_run = 0; end
    cf_p = cal_out; f1_p = fout1; f2_p = fout2;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", {28'd0, fout1, fout2, cal_out, rev_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_clear();
  endtask

  task automatic send(input logic signed [15:0] v, input int spacing);
    @(negedge clk);
    pwr_valid = 1'b1;
    pwr_sample = v;
    @(negedge clk);
    pwr_valid = 1'b0;
    repeat (spacing) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]         fs;
    logic               cal;
    logic signed [15:0] v;
    logic [15:0]        n;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{2'd0, 1'b0,  16'sd500, 16'd40},   // R3 R4 slowest rate
    '{2'd1, 1'b0, -16'sd700, 16'd40},   // R10 negative input
    '{2'd2, 1'b1,  16'sd100, 16'd60},   // R4 high ratio
    '{2'd3, 1'b1, -16'sd60,  16'd100},  // R7 high-rate width
    '{2'd3, 1'b0,  16'sd200, 16'd50},   // R5 odd slow count
    '{2'd2, 1'b0,  16'sd10,  16'd40},   // R9 far below floor
    '{2'd1, 1'b1, -16'sd15,  16'd40},   // R9 one below floor
    '{2'd0, 1'b1,  16'sd16,  16'd100}   // R9 exactly at floor
  };

  initial begin
    // Table walk.
    for (int i = 0; i < 8; i++) begin
      int mag, energy, q_slow, sh, q_cal, e_cf, e_f;
      fsel = VT[i].fs;
      cal_sel = VT[i].cal;
      do_reset();
      for (int k = 0; k < int'(VT[i].n); k++) send(VT[i].v, 14);
      repeat (40) @(negedge clk);
      mag = (VT[i].v < 0) ? -int'(VT[i].v) : int'(VT[i].v);
      energy = (mag >= 16) ? mag * int'(VT[i].n) : 0;
      q_slow = 1024 << (3 - int'(VT[i].fs));
      sh = VT[i].cal ? 4 : 2;
      q_cal = q_slow >> sh;
      e_cf = energy / q_cal;
      e_f = e_cf >> sh;
      chk($sformatf("R3 R9 R10 cal count v%0d", i), cf_rise, e_cf);
      chk($sformatf("R4 R5 fout1 count v%0d", i), f1_rise, (e_f + 1) / 2);
      chk($sformatf("R4 R5 fout2 count v%0d", i), f2_rise, e_f / 2);
      chk($sformatf("R5 overlap v%0d", i), both_hi, 0);
      chk($sformatf("R4 sync v%0d", i), unsync, 0);
      chk($sformatf("R2 sign v%0d", i), int'(rev_flag), (VT[i].v < 0) ? 1 : 0);
      if (e_cf > 0)
        chk($sformatf("R7 cal width v%0d", i), cf_last,
            (VT[i].fs == 2'd3 && VT[i].cal) ? 2 : 6);
      if (e_f > 0)
        chk($sformatf("R6 slow width v%0d", i), f_last, 8);
    end

    // R11: pulse rises on the second edge after the crossing sample is presented.
    fsel = 2'd3; cal_sel = 1'b0;
    do_reset();
    @(negedge clk);
    pwr_valid = 1'b1; pwr_sample = 16'sd256;
    @(negedge clk);
    pwr_valid = 1'b0;
    chk("R11 not yet high", int'(cal_out), 0);
    @(negedge clk);
    chk("R11 high on next edge", int'(cal_out), 1);
    repeat (20) @(negedge clk);

    // R8: back-to-back events truncate and re-launch.
    do_reset();
    @(negedge clk); pwr_valid = 1'b1; pwr_sample = 16'sd256;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); pwr_valid = 1'b0;
    chk("R8 truncated low", int'(cal_out), 0);
    @(negedge clk);
    chk("R8 relaunch high", int'(cal_out), 1);
    repeat (20) @(negedge clk);
    chk("R8 all events kept", cf_rise, 3);
    chk("R8 last pulse full width", cf_last, 6);

    // R1: leftover energy does not survive reset.
    do_reset();
    send(16'sd200, 14); send(16'sd200, 14); send(16'sd200, 14);
    repeat (10) @(negedge clk);
    chk("R1 pre-reset pulses", cf_rise, 2);
    do_reset();
    send(16'sd200, 14);
    repeat (20) @(negedge clk);
    chk("R1 accumulator cleared", cf_rise, 0);

    // R2: floor sample still sets sign; no strobe holds it.
    @(negedge clk); pwr_valid = 1'b1; pwr_sample = -16'sd5;
    @(negedge clk); pwr_valid = 1'b0; pwr_sample = 16'sd100;
    chk("R2 sign from floor sample", int'(rev_flag), 1);
    repeat (3) @(negedge clk);
    chk("R2 sign held", int'(rev_flag), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule